// File: doc/BRIEF.md
# Video Memory Block-Copy DMA

This engine copies bytes from anywhere in a 64 KiB system address space into the 8 KiB video memory window at 0x8000-0x9FFF. Software loads a source pointer and a destination pointer through four byte-wide address registers. It then writes a control register, and that one write picks the mode. A general transfer moves the whole requested length in one go. A blanking transfer is armed to move one 16-byte chunk each time the display enters horizontal blank.

The engine drives a simple memory port. It issues one read per clock, and the returned byte is written to video memory in the following clock. At the end of every transfer or chunk it writes the advanced pointers back into the address registers, so a later transfer continues from where the last one stopped. The engine raises `busy` while bytes are moving. It also latches a cycle-cost figure that a stall controller elsewhere can use.

Register select codes: 0 source high, 1 source low, 2 destination high, 3 destination low, 4 control/length.

Top module: `vram_block_dma`

## Requirements
- R1: The source address is {source-high[7:0], source-low[7:4], 4'h0}. Source-low bits 3:0 are dropped, so select 1 reads back {nibble, 4'h0}. Successive reads step by +1 and wrap at 0xFFFF.
- R2: The destination address is {3'b100, destination-high[4:0], destination-low[7:4], 4'h0}. Select 2 reads {3'b000, bits 4:0}. Successive writes step by +1 inside the 13-bit window, so 0x9FFF is followed by 0x8000.
- R3: A control write with bit 7 clear while no blanking transfer is armed starts a general transfer of (bits 6:0 + 1) × 16 bytes. `busy` is high for exactly bytes+1 cycles, starting at the clock edge that takes the write. Each byte read is written in the next cycle, in order.
- R4: When a transfer or chunk ends, the address registers read back the advanced pointers. After a general transfer the control register reads 0xFF.
- R5: `xfer_cost` latches (460 >> fast_speed) + 16 × chunks when a general transfer starts, and 16 when a blanking chunk starts.
- R6: A control write with bit 7 set arms blanking mode and loads the length with bits 6:0 (bit 7 reads 0). Nothing moves until horizontal blank (lcd_mode 0) is entered.
- R7: If lcd_mode is already 0 when blanking mode is armed, one chunk starts at once.
- R8: While armed, each change of lcd_mode from non-zero to 0 starts exactly one 16-byte chunk. Staying in mode 0 starts nothing more.
- R9: Each chunk decrements the length. The chunk that ends with length 0 leaves the register at 0xFF and disarms the mode, so later blanking entries move nothing.
- R10: A control write with bit 7 clear while armed cancels the mode and loads the length with bits 6:0. No bytes move then or on later blanking entries.
- R11: Register writes that arrive while `busy` is high are ignored.
- R12: After reset all address registers read 0, the control register reads 0xFF, and `busy`, `mem_rd_en` and `mem_wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select for writes |
| reg_wdata | input | 8 | Register write data |
| reg_rd_sel | input | 3 | Register select for reads |
| reg_rdata | output | 8 | Register read data (combinational) |
| lcd_mode | input | 2 | Display mode; 0 is horizontal blank |
| fast_speed | input | 1 | Double-speed flag for the cost figure |
| mem_rd_en | output | 1 | Source read request |
| mem_rd_addr | output | 16 | Source read address |
| mem_rd_data | input | 8 | Read data, valid the cycle after the request |
| mem_wr_en | output | 1 | Video memory write strobe |
| mem_wr_addr | output | 16 | Video memory write address |
| mem_wr_data | output | 8 | Video memory write data |
| busy | output | 1 | Transfer in progress |
| xfer_cost | output | 16 | Cycle cost of the latest transfer or chunk |

## Verification
The bench targets pointer wrap at both ends. A source starting at 0xFFF0 must continue at 0x0000. A destination at 0x9FF0 must fold to 0x8000, and a design that lets it carry into bit 13 would write outside video memory. Blanking mode is checked for one chunk per entry into mode 0. A level-triggered design would keep copying while the display sits in blank. The final chunk must disarm the mode, and a design that misses the wrap to 0xFF would copy forever. Writes made during a transfer must be dropped, and cancel must differ from start: a design that treats a bit-7-clear write as a general transfer while armed would move data when it should only stop.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
  localparam int CHUNK_BYTES = 16;
  localparam int LEN_W       = 7;
  localparam int CNT_W       = $clog2((2 ** LEN_W) * CHUNK_BYTES + 1);
  localparam int COST_W      = 16;
  localparam logic [COST_W-1:0] BASE_COST = 16'd460;
  localparam logic [1:0] MODE_HBLANK = 2'b00;

  typedef enum logic [2:0] {
    SEL_SRC_HI = 3'd0,
    SEL_SRC_LO = 3'd1,
    SEL_DST_HI = 3'd2,
    SEL_DST_LO = 3'd3,
    SEL_CTRL   = 3'd4
  } reg_sel_e;

  function automatic logic [15:0] form_src(input logic [7:0] hi, input logic [3:0] lo_nib);
    return {hi, lo_nib, 4'h0};
  endfunction

  function automatic logic [12:0] form_dst(input logic [4:0] hi, input logic [3:0] lo_nib);
    return {hi, lo_nib, 4'h0};
  endfunction

  function automatic logic [CNT_W-1:0] span_bytes(input logic [LEN_W-1:0] len);
    return ({{(CNT_W-LEN_W){1'b0}}, len} + 1'b1) << $clog2(CHUNK_BYTES);
  endfunction

  function automatic logic [COST_W-1:0] bulk_cost(input logic fast, input logic [LEN_W-1:0] len);
    return (BASE_COST >> fast) + {{(COST_W-CNT_W){1'b0}}, span_bytes(len)};
  endfunction
endpackage

// File: rtl/vdma_mover.sv
module vdma_mover
  import vdma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic [CNT_W-1:0] nbytes,
  input  logic [15:0]      src_start,
  input  logic [12:0]      dst_start,
  output logic             mem_rd_en,
  output logic [15:0]      mem_rd_addr,
  input  logic [7:0]       mem_rd_data,
  output logic             mem_wr_en,
  output logic [15:0]      mem_wr_addr,
  output logic [7:0]       mem_wr_data,
  output logic             busy,
  output logic             done,
  output logic [15:0]      end_src,
  output logic [12:0]      end_dst
);
  logic [CNT_W-1:0] issue_left;
  logic [15:0]      src_ptr;
  logic [12:0]      dst_ptr;
  logic             wr_pend;
  logic             issuing;

  assign issuing = (issue_left != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      issue_left <= '0;
      src_ptr    <= '0;
      dst_ptr    <= '0;
      wr_pend    <= 1'b0;
    end else if (launch) begin
      issue_left <= nbytes;
      src_ptr    <= src_start;
      dst_ptr    <= dst_start;
      wr_pend    <= 1'b0;
    end else begin
      if (issuing) begin
        issue_left <= issue_left - 1'b1;
        src_ptr    <= src_ptr + 16'd1;
      end
      wr_pend <= issuing;
      if (wr_pend) dst_ptr <= dst_ptr + 13'd1;
    end
  end

  assign mem_rd_en   = issuing;
  assign mem_rd_addr = src_ptr;
  assign mem_wr_en   = wr_pend;
  assign mem_wr_addr = {3'b100, dst_ptr};
  assign mem_wr_data = mem_rd_data;
  assign busy        = issuing | wr_pend;
  assign done        = wr_pend & ~issuing;
  assign end_src     = src_ptr;
  assign end_dst     = dst_ptr + 13'd1;

  assert_wr_follows_rd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> mem_wr_en);
  assert_src_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && issue_left > 1) |=> (mem_rd_addr == $past(mem_rd_addr) + 16'd1));
  assert_dst_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && !done) |=> (mem_wr_en && mem_wr_addr[12:0] == $past(mem_wr_addr[12:0]) + 13'd1));
endmodule

// File: rtl/vdma_regs.sv
module vdma_regs
  import vdma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_ok,
  input  logic [2:0]  wr_sel,
  input  logic [7:0]  wr_data,
  input  logic        arm,
  input  logic        cancel,
  input  logic        launch,
  input  logic        launch_chunk,
  input  logic        busy,
  input  logic        done,
  input  logic [15:0] end_src,
  input  logic [12:0] end_dst,
  input  logic [2:0]  rd_sel,
  output logic [15:0] src_addr,
  output logic [12:0] dst_off,
  output logic        armed,
  output logic [7:0]  rd_data
);
  logic [7:0] src_hi_q;
  logic [3:0] src_lo_q;
  logic [4:0] dst_hi_q;
  logic [3:0] dst_lo_q;
  logic [7:0] len_q;
  logic       armed_q;
  logic       chunk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_hi_q <= '0;
      src_lo_q <= '0;
      dst_hi_q <= '0;
      dst_lo_q <= '0;
      len_q    <= 8'hFF;
      armed_q  <= 1'b0;
      chunk_q  <= 1'b0;
    end else begin
      if (launch) chunk_q <= launch_chunk;
      if (wr_ok) begin
        case (wr_sel)
          SEL_SRC_HI: src_hi_q <= wr_data;
          SEL_SRC_LO: src_lo_q <= wr_data[7:4];
          SEL_DST_HI: dst_hi_q <= wr_data[4:0];
          SEL_DST_LO: dst_lo_q <= wr_data[7:4];
          default: ;
        endcase
      end
      if (arm) begin
        len_q   <= {1'b0, wr_data[6:0]};
        armed_q <= 1'b1;
      end else if (cancel) begin
        len_q   <= {1'b0, wr_data[6:0]};
        armed_q <= 1'b0;
      end
      if (done) begin
        src_hi_q <= end_src[15:8];
        src_lo_q <= end_src[7:4];
        dst_hi_q <= end_dst[12:8];
        dst_lo_q <= end_dst[7:4];
        if (chunk_q) begin
          len_q <= len_q - 8'd1;
          if (len_q == 8'd0) armed_q <= 1'b0;
        end else begin
          len_q <= 8'hFF;
        end
      end
    end
  end

  assign src_addr = form_src(src_hi_q, src_lo_q);
  assign dst_off  = form_dst(dst_hi_q, dst_lo_q);
  assign armed    = armed_q;

  always_comb begin
    case (rd_sel)
      SEL_SRC_HI: rd_data = src_hi_q;
      SEL_SRC_LO: rd_data = {src_lo_q, 4'h0};
      SEL_DST_HI: rd_data = {3'b000, dst_hi_q};
      SEL_DST_LO: rd_data = {dst_lo_q, 4'h0};
      SEL_CTRL:   rd_data = len_q;
      default:    rd_data = 8'h00;
    endcase
  end

  assert_bulk_len_ff_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !chunk_q) |=> (len_q == 8'hFF));
  assert_last_chunk_disarms_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && chunk_q && len_q == 8'd0) |=> (!armed_q && len_q == 8'hFF));
  assert_busy_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable({src_hi_q, src_lo_q, dst_hi_q, dst_lo_q, len_q, armed_q}));
endmodule

// File: rtl/vram_block_dma.sv
module vram_block_dma
  import vdma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic [2:0]  reg_sel,
  input  logic [7:0]  reg_wdata,
  input  logic [2:0]  reg_rd_sel,
  output logic [7:0]  reg_rdata,
  input  logic [1:0]  lcd_mode,
  input  logic        fast_speed,
  output logic        mem_rd_en,
  output logic [15:0] mem_rd_addr,
  input  logic [7:0]  mem_rd_data,
  output logic        mem_wr_en,
  output logic [15:0] mem_wr_addr,
  output logic [7:0]  mem_wr_data,
  output logic        busy,
  output logic [15:0] xfer_cost
);
  logic              busy_w, done_w, armed_w;
  logic              wr_ok, wr_ctrl, arm_w, cancel_w, bulk_w;
  logic              hbl_entry, chunk_w, launch_w;
  logic [1:0]        mode_q;
  logic [15:0]       src_addr, end_src;
  logic [12:0]       dst_off, end_dst;
  logic [CNT_W-1:0]  nbytes;
  logic [COST_W-1:0] cost_q;

  assign wr_ok     = reg_wr_en & ~busy_w;
  assign wr_ctrl   = wr_ok & (reg_sel == SEL_CTRL);
  assign arm_w     = wr_ctrl & reg_wdata[7];
  assign cancel_w  = wr_ctrl & ~reg_wdata[7] & armed_w;
  assign bulk_w    = wr_ctrl & ~reg_wdata[7] & ~armed_w;
  assign hbl_entry = (lcd_mode == MODE_HBLANK) && (mode_q != MODE_HBLANK);
  assign chunk_w   = (arm_w && lcd_mode == MODE_HBLANK) ||
                     (armed_w && hbl_entry && !busy_w && !wr_ctrl);
  assign launch_w  = chunk_w | bulk_w;
  assign nbytes    = chunk_w ? CNT_W'(CHUNK_BYTES) : span_bytes(reg_wdata[LEN_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_HBLANK;
      cost_q <= '0;
    end else begin
      mode_q <= lcd_mode;
      if (chunk_w)     cost_q <= COST_W'(CHUNK_BYTES);
      else if (bulk_w) cost_q <= bulk_cost(fast_speed, reg_wdata[LEN_W-1:0]);
    end
  end

  vdma_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .wr_sel(reg_sel), .wr_data(reg_wdata),
    .arm(arm_w), .cancel(cancel_w), .launch(launch_w), .launch_chunk(chunk_w),
    .busy(busy_w), .done(done_w), .end_src(end_src), .end_dst(end_dst),
    .rd_sel(reg_rd_sel), .src_addr(src_addr), .dst_off(dst_off),
    .armed(armed_w), .rd_data(reg_rdata)
  );

  vdma_mover u_mover (
    .clk(clk), .rst_n(rst_n), .launch(launch_w), .nbytes(nbytes),
    .src_start(src_addr), .dst_start(dst_off),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .busy(busy_w), .done(done_w), .end_src(end_src), .end_dst(end_dst)
  );

  assign busy      = busy_w;
  assign xfer_cost = cost_q;

  assert_no_launch_while_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy_w |-> !launch_w);
endmodule

// File: tb/test_vram_block_dma.sv
module test_vram_block_dma;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [7:0]  reg_wdata = '0;
  logic [2:0]  reg_rd_sel = '0;
  logic [7:0]  reg_rdata;
  logic [1:0]  lcd_mode = 2'd2;
  logic        fast_speed = 1'b0;
  logic        mem_rd_en, mem_wr_en, busy;
  logic [15:0] mem_rd_addr, mem_wr_addr, xfer_cost;
  logic [7:0]  mem_rd_data, mem_wr_data;

  int checks = 0, fails = 0;
  int cap_n = 0, busy_cnt = 0;
  logic [15:0] cap_addr [0:2047];
  logic [7:0]  cap_data [0:2047];

  vram_block_dma i_vram_block_dma (.*);

  always #5 clk = ~clk;

  function automatic logic [7:0] src_byte(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
  endfunction

  always_ff @(posedge clk) mem_rd_data <= src_byte(mem_rd_addr);

  always @(negedge clk) begin
    if (mem_wr_en && cap_n < 2048) begin
      cap_addr[cap_n] = mem_wr_addr;
      cap_data[cap_n] = mem_wr_data;
      cap_n++;
    end
    if (busy) busy_cnt++;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] s, input logic [7:0] v);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_sel = s; reg_wdata = v;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] s, output logic [7:0] v);
    reg_rd_sel = s;
    #1 v = reg_rdata;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 4000 && busy; k++) @(negedge clk);
  endtask

  task automatic clear_log();
    cap_n = 0; busy_cnt = 0;
  endtask

  task automatic check_xfer(input string req, input logic [15:0] s0, input logic [12:0] d0, input int nb);
    int bad = 0;
    logic [15:0] se; logic [12:0] de; logic [7:0] v;
    chk(cap_n == nb, req, "byte count", cap_n, nb);
    chk(busy_cnt == nb + 1, "R3", "busy cycles", busy_cnt, nb + 1);
    for (int i = 0; i < nb && i < cap_n; i++) begin
      if (cap_addr[i] != {3'b100, 13'(d0 + 13'(i))} || cap_data[i] != src_byte(16'(s0 + 16'(i))))
        bad++;
    end
    chk(bad == 0, req, "mismatched bytes", bad, 0);
    se = 16'(s0 + 16'(nb)); de = 13'(d0 + 13'(nb));
    rreg(3'd0, v); chk(v == se[15:8], "R4", "src hi writeback", v, se[15:8]);
    rreg(3'd1, v); chk(v == {se[7:4], 4'h0}, "R4", "src lo writeback", v, {se[7:4], 4'h0});
    rreg(3'd2, v); chk(v == {3'b0, de[12:8]}, "R4", "dst hi writeback", v, {3'b0, de[12:8]});
    rreg(3'd3, v); chk(v == {de[7:4], 4'h0}, "R4", "dst lo writeback", v, {de[7:4], 4'h0});
  endtask

  task automatic load_ptrs(input logic [7:0] sh, sl, dh, dl);
    wreg(3'd0, sh); wreg(3'd1, sl); wreg(3'd2, dh); wreg(3'd3, dl);
  endtask

  task automatic run_bulk(input string req, input logic [7:0] sh, sl, dh, dl,
                          input logic [6:0] len, input bit spd);
    logic [7:0] v; int nb; int cost;
    fast_speed = spd;
    load_ptrs(sh, sl, dh, dl);
    clear_log();
    wreg(3'd4, {1'b0, len});
    wait_idle();
    nb = (int'(len) + 1) * 16;
    cost = (spd ? 230 : 460) + nb;
    check_xfer(req, {sh, sl[7:4], 4'h0}, {dh[4:0], dl[7:4], 4'h0}, nb);
    rreg(3'd4, v); chk(v == 8'hFF, "R4", "length after bulk", v, 8'hFF);
    chk(xfer_cost == 16'(cost), "R5", "bulk cost", xfer_cost, cost);
  endtask

  task automatic hbl_pulse();
    @(negedge clk); lcd_mode = 2'd3;
    repeat (2) @(negedge clk);
    lcd_mode = 2'd0;
    @(negedge clk);
    wait_idle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [15:0] s0; logic [12:0] d0;
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    for (int s = 0; s < 4; s++) begin
      rreg(3'(s), v); chk(v == 8'h00, "R12", "address reg after reset", v, 0);
    end
    rreg(3'd4, v); chk(v == 8'hFF, "R12", "length after reset", v, 8'hFF);
    chk(!busy && !mem_rd_en && !mem_wr_en, "R12", "idle outputs", {busy, mem_rd_en, mem_wr_en}, 0);

    // R1/R2 low bits dropped, readback forms
    load_ptrs(8'h12, 8'h3F, 8'hE5, 8'h7C);
    rreg(3'd1, v); chk(v == 8'h30, "R1", "src lo readback", v, 8'h30);
    rreg(3'd2, v); chk(v == 8'h05, "R2", "dst hi readback", v, 8'h05);
    run_bulk("R1", 8'h12, 8'h3F, 8'hE5, 8'h7C, 7'd2, 1'b0);

    // R2 destination wrap, R1 source wrap, fast speed cost
    run_bulk("R2", 8'hFF, 8'hF0, 8'h1F, 8'hF0, 7'd1, 1'b1);

    // R11 writes while busy are dropped
    fast_speed = 1'b0;
    load_ptrs(8'h40, 8'h00, 8'h02, 8'h00);
    clear_log();
    wreg(3'd4, 8'h03);
    wreg(3'd0, 8'h77);
    wreg(3'd4, 8'h80);
    wait_idle();
    check_xfer("R11", 16'h4000, 13'h0200, 64);
    rreg(3'd4, v); chk(v == 8'hFF, "R11", "length not re-armed", v, 8'hFF);
    clear_log(); hbl_pulse();
    chk(cap_n == 0, "R11", "blank entry after dropped arm", cap_n, 0);

    // R3 random bulk transfers
    for (int t = 0; t < 8; t++) begin
      run_bulk("R3", 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
               7'($urandom % 12), 1'($urandom));
    end

    // R6/R8/R9 armed blanking mode, three chunks
    lcd_mode = 2'd2;
    load_ptrs(8'hA1, 8'h20, 8'h03, 8'h40);
    clear_log();
    wreg(3'd4, 8'h82);
    repeat (6) @(negedge clk);
    rreg(3'd4, v); chk(v == 8'h02, "R6", "armed length", v, 8'h02);
    chk(cap_n == 0 && !busy, "R6", "no move before blank", cap_n, 0);
    s0 = 16'hA120; d0 = 13'h0340;
    for (int c = 0; c < 3; c++) begin
      clear_log(); hbl_pulse();
      check_xfer("R8", s0, d0, 16);
      chk(xfer_cost == 16'd16, "R5", "chunk cost", xfer_cost, 16);
      rreg(3'd4, v); chk(v == 8'(1 - c), "R9", "length decrement", v, 8'(1 - c));
      s0 = s0 + 16'd16; d0 = d0 + 13'd16;
      if (c == 0) begin
        clear_log(); repeat (20) @(negedge clk);
        chk(cap_n == 0, "R8", "no repeat while in blank", cap_n, 0);
      end
    end
    clear_log(); hbl_pulse();
    chk(cap_n == 0, "R9", "disarmed after last chunk", cap_n, 0);

    // R7 immediate chunk when already in blank
    lcd_mode = 2'd0;
    load_ptrs(8'h05, 8'h50, 8'h10, 8'h00);
    clear_log();
    wreg(3'd4, 8'h81);
    wait_idle();
    check_xfer("R7", 16'h0550, 13'h1000, 16);
    rreg(3'd4, v); chk(v == 8'h00, "R7", "length after immediate chunk", v, 8'h00);
    clear_log(); hbl_pulse();
    check_xfer("R9", 16'h0560, 13'h1010, 16);
    rreg(3'd4, v); chk(v == 8'hFF, "R9", "length after final chunk", v, 8'hFF);

    // R10 cancel
    lcd_mode = 2'd2;
    load_ptrs(8'h33, 8'h00, 8'h08, 8'h00);
    wreg(3'd4, 8'h85);
    clear_log(); hbl_pulse();
    check_xfer("R10", 16'h3300, 13'h0800, 16);
    lcd_mode = 2'd2;
    clear_log();
    wreg(3'd4, 8'h03);
    repeat (5) @(negedge clk);
    rreg(3'd4, v); chk(v == 8'h03, "R10", "length after cancel", v, 8'h03);
    chk(cap_n == 0, "R10", "cancel moves nothing", cap_n, 0);
    hbl_pulse();
    chk(cap_n == 0, "R10", "blank entry after cancel", cap_n, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule